// File: doc/BRIEF.md
# Video Memory Transfer Engine

This block moves data into the video memories of a display controller without processor involvement. Once a command decoder has chosen a transfer kind, a destination start and a destination memory, a single start pulse runs the whole transfer. Three kinds exist. In memory mode, 16-bit words are fetched from system memory over a valid/ready read port. In copy mode, bytes are read from video RAM and written back to video RAM. In fill mode, one constant byte is written repeatedly into video RAM.

The source address and the length come from five 8-bit register values held elsewhere. The destination advances after every transferred unit by a programmable stride, and it wraps within the size of the memory being written. All writes leave through one valid/ready byte write port that carries a target select. The port accepts at most one byte per clock. Back-pressure is simple: a request (`rd_valid` or `wr_valid`) stays asserted, with its address and target unchanged, until the matching ready is high at a clock edge. `rd_data` is taken in the same edge that completes the read handshake. The copy source is read through a combinational video RAM read port.

Top module: `vdma_engine`

## Requirements
- R1: The source address is {src_hi[6:0], src_mid, src_lo, 1'b0} (24 bits). When src_hi[7] is 1, bit 23 of that address is forced to 0. The first memory-mode read request carries this address.
- R2: The length is {len_hi, len_lo}. A start with length 0, or a start with mode code 3, does nothing: busy stays low and no read or write is issued.
- R3: Memory mode (mode code 0) works one word at a time while the remaining count is nonzero. For each word it issues one read, writes data[15:8] to the destination, then writes data[7:0] to destination+1 (wrapped). The source then advances by 2 and the count drops by 2, saturating at 0, so an odd length rounds up to a whole word.
- R4: Copy mode (mode code 1) writes the video RAM byte at the low 16 bits of the source to the video RAM destination. Each byte adds 1 to the source and subtracts 1 from the count.
- R5: Fill mode (mode code 2) writes the fill byte to the video RAM destination once per count.
- R6: The destination advances by the stride after each word or byte. It wraps modulo the size of the written memory: target code 0 is video RAM (65536 bytes), code 1 is colour RAM (128 bytes), code 2 is scroll RAM (80 bytes), and code 3 acts as code 0. The target input applies only in memory mode; copy and fill always write video RAM.
- R7: busy is low after reset. It is high from the cycle after an accepted start, and low from the cycle after the last write handshake.
- R8: A start that arrives while busy is ignored. The running transfer completes unchanged.
- R9: Under back-pressure, a pending request holds its valid, address and target until ready. Read and write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer start |
| mode | input | 2 | 0 memory, 1 copy, 2 fill, 3 none |
| tgt_sel | input | 2 | Destination memory for memory mode |
| dst_base | input | 16 | First destination address |
| stride | input | 8 | Destination step per unit |
| src_lo | input | 8 | Source register, low |
| src_mid | input | 8 | Source register, middle |
| src_hi | input | 8 | Source register, high; bit 7 marks a non-memory mode |
| len_lo | input | 8 | Length, low byte |
| len_hi | input | 8 | Length, high byte |
| fill_value | input | 8 | Low byte of the fill word |
| rd_valid | output | 1 | System memory read request |
| rd_addr | output | 24 | System memory byte address |
| rd_ready | input | 1 | Read accepted; rd_data valid |
| rd_data | input | 16 | Read word |
| vr_rd_addr | output | 16 | Copy source address in video RAM |
| vr_rd_data | input | 8 | Video RAM byte at vr_rd_addr, same cycle |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Write accepted |
| wr_tgt | output | 2 | Written memory code |
| wr_addr | output | 16 | Write byte address |
| wr_data | output | 8 | Write byte |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that `vr_rd_data` depends only on `vr_rd_addr`, so copy data cannot change while a write is stalled. The bench drives start for exactly one cycle from negative edges. It models video RAM and system memory as fixed functions of the address. It throttles both ready inputs by toggling them every cycle, so that stalled requests are exercised inside those limits.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {
    XM_MEM  = 2'd0,
    XM_COPY = 2'd1,
    XM_FILL = 2'd2,
    XM_NONE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    DT_VRAM  = 2'd0,
    DT_CRAM  = 2'd1,
    DT_VSRAM = 2'd2,
    DT_ALIAS = 2'd3
  } dest_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_HI,
    ST_WR_LO,
    ST_WR_BYTE
  } eng_state_e;
endpackage

// File: rtl/vdma_src.sv
module vdma_src #(
  parameter int REG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [REG_W-1:0]     reg_lo,
  input  logic [REG_W-1:0]     reg_mid,
  input  logic [REG_W-1:0]     reg_hi,
  input  logic [REG_W-1:0]     len_lo,
  input  logic [REG_W-1:0]     len_hi,
  input  logic                 step,
  input  logic                 wide,
  output logic [3*REG_W-1:0]   src_addr,
  output logic                 last
);
  localparam int SRC_W = 3 * REG_W;
  localparam int LEN_W = 2 * REG_W;

  logic [SRC_W-1:0] formed;
  logic [LEN_W-1:0] remain;

  // source address built from three registers with a one-bit left shift
  always_comb begin
    formed = {reg_hi[REG_W-2:0], reg_mid, reg_lo, 1'b0};
    if (reg_hi[REG_W-1]) formed[SRC_W-1] = 1'b0;
  end

  assign last = wide ? (remain <= LEN_W'(2)) : (remain == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      src_addr <= formed;
      remain   <= {len_hi, len_lo};
    end else if (step) begin
      if (wide) begin
        src_addr <= src_addr + SRC_W'(2);
        remain   <= (remain > LEN_W'(2)) ? remain - LEN_W'(2) : '0;
      end else begin
        src_addr <= src_addr + SRC_W'(1);
        remain   <= remain - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/vdma_dst.sv
module vdma_dst
  import vdma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int STRIDE_W    = 8,
  parameter int VRAM_BYTES  = 65536,
  parameter int CRAM_BYTES  = 128,
  parameter int VSRAM_BYTES = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   base,
  input  dest_e               tgt_in,
  input  logic [STRIDE_W-1:0] stride_in,
  input  logic                step,
  output dest_e               tgt,
  output logic [ADDR_W-1:0]   addr,
  output logic [ADDR_W-1:0]   addr_plus1
);
  localparam int SUM_W = ADDR_W + 1;

  logic [STRIDE_W-1:0] stride_q;
  dest_e               tgt_eff;

  function automatic logic [ADDR_W-1:0] wrap(input logic [SUM_W-1:0] v, input dest_e t);
    case (t)
      DT_CRAM:  wrap = ADDR_W'(32'(v) % CRAM_BYTES);
      DT_VSRAM: wrap = ADDR_W'(32'(v) % VSRAM_BYTES);
      default:  wrap = ADDR_W'(32'(v) % VRAM_BYTES);
    endcase
  endfunction

  assign tgt_eff    = (tgt_in == DT_ALIAS) ? DT_VRAM : tgt_in;
  assign addr_plus1 = wrap({1'b0, addr} + SUM_W'(1), tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt      <= DT_VRAM;
      addr     <= '0;
      stride_q <= '0;
    end else if (load) begin
      tgt      <= tgt_eff;
      addr     <= wrap({1'b0, base}, tgt_eff);
      stride_q <= stride_in;
    end else if (step) begin
      addr <= wrap({1'b0, addr} + SUM_W'(stride_q), tgt);
    end
  end
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_mode_e mode_in,
  input  logic       len_zero,
  input  logic       rd_ready,
  input  logic       wr_ready,
  input  logic       last,
  output eng_state_e state,
  output xfer_mode_e mode_q,
  output logic       load,
  output logic       step,
  output logic       capture,
  output logic       wide
);
  eng_state_e nxt;

  assign load    = (state == ST_IDLE) && start && (mode_in != XM_NONE) && !len_zero;
  assign step    = wr_ready && ((state == ST_WR_LO) || (state == ST_WR_BYTE));
  assign capture = (state == ST_READ) && rd_ready;
  assign wide    = (mode_q == XM_MEM);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (load) nxt = (mode_in == XM_MEM) ? ST_READ : ST_WR_BYTE;
      ST_READ:    if (rd_ready) nxt = ST_WR_HI;
      ST_WR_HI:   if (wr_ready) nxt = ST_WR_LO;
      ST_WR_LO:   if (wr_ready) nxt = last ? ST_IDLE : ST_READ;
      ST_WR_BYTE: if (wr_ready) nxt = last ? ST_IDLE : ST_WR_BYTE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= XM_NONE;
    end else begin
      state <= nxt;
      if (load) mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int VRAM_BYTES  = 65536,
  parameter int CRAM_BYTES  = 128,
  parameter int VSRAM_BYTES = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [1:0]           tgt_sel,
  input  logic [ADDR_W-1:0]    dst_base,
  input  logic [REG_W-1:0]     stride,
  input  logic [REG_W-1:0]     src_lo,
  input  logic [REG_W-1:0]     src_mid,
  input  logic [REG_W-1:0]     src_hi,
  input  logic [REG_W-1:0]     len_lo,
  input  logic [REG_W-1:0]     len_hi,
  input  logic [REG_W-1:0]     fill_value,
  output logic                 rd_valid,
  output logic [3*REG_W-1:0]   rd_addr,
  input  logic                 rd_ready,
  input  logic [2*REG_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]    vr_rd_addr,
  input  logic [REG_W-1:0]     vr_rd_data,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [1:0]           wr_tgt,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [REG_W-1:0]     wr_data,
  output logic                 busy
);
  localparam int SRC_W  = 3 * REG_W;
  localparam int WORD_W = 2 * REG_W;

  eng_state_e       state;
  xfer_mode_e       mode_q;
  xfer_mode_e       mode_in;
  dest_e            tgt_in;
  dest_e            tgt_q;
  logic             load, step, capture, wide, last, len_zero;
  logic [SRC_W-1:0] src_addr;
  logic [ADDR_W-1:0] dst_addr, dst_addr1;
  logic [WORD_W-1:0] word_q;
  logic [REG_W-1:0]  fill_q;

  assign mode_in  = xfer_mode_e'(mode);
  assign len_zero = ({len_hi, len_lo} == '0);
  assign tgt_in   = (mode_in == XM_MEM) ? dest_e'(tgt_sel) : DT_VRAM;

  vdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
    .len_zero(len_zero), .rd_ready(rd_ready), .wr_ready(wr_ready),
    .last(last), .state(state), .mode_q(mode_q), .load(load),
    .step(step), .capture(capture), .wide(wide)
  );

  vdma_src #(.REG_W(REG_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .reg_lo(src_lo),
    .reg_mid(src_mid), .reg_hi(src_hi), .len_lo(len_lo), .len_hi(len_hi),
    .step(step), .wide(wide), .src_addr(src_addr), .last(last)
  );

  vdma_dst #(
    .ADDR_W(ADDR_W), .STRIDE_W(REG_W), .VRAM_BYTES(VRAM_BYTES),
    .CRAM_BYTES(CRAM_BYTES), .VSRAM_BYTES(VSRAM_BYTES)
  ) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .base(dst_base),
    .tgt_in(tgt_in), .stride_in(stride), .step(step), .tgt(tgt_q),
    .addr(dst_addr), .addr_plus1(dst_addr1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      fill_q <= '0;
    end else begin
      if (capture) word_q <= rd_data;
      if (load)    fill_q <= fill_value;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign rd_valid   = (state == ST_READ);
  assign rd_addr    = src_addr;
  assign vr_rd_addr = src_addr[ADDR_W-1:0];
  assign wr_valid   = (state == ST_WR_HI) || (state == ST_WR_LO) || (state == ST_WR_BYTE);
  assign wr_tgt     = tgt_q;
  assign wr_addr    = (state == ST_WR_LO) ? dst_addr1 : dst_addr;

  always_comb begin
    case (state)
      ST_WR_HI:   wr_data = word_q[WORD_W-1:REG_W];
      ST_WR_LO:   wr_data = word_q[REG_W-1:0];
      ST_WR_BYTE: wr_data = (mode_q == XM_COPY) ? vr_rd_data : fill_q;
      default:    wr_data = '0;
    endcase
  end
endmodule

// File: rtl/vdma_chk.sv
module vdma_chk #(
  parameter int REG_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int VRAM_BYTES  = 65536,
  parameter int CRAM_BYTES  = 128,
  parameter int VSRAM_BYTES = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        mode,
  input logic [REG_W-1:0]  len_lo,
  input logic [REG_W-1:0]  len_hi,
  input logic              rd_valid,
  input logic [3*REG_W-1:0] rd_addr,
  input logic              rd_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [1:0]        wr_tgt,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy
);
  logic len_nz;
  int   lim;
  assign len_nz = ({len_hi, len_lo} != '0);
  always_comb begin
    case (wr_tgt)
      2'd1:    lim = CRAM_BYTES;
      2'd2:    lim = VSRAM_BYTES;
      default: lim = VRAM_BYTES;
    endcase
  end

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (!len_nz || mode == 2'd3)) |=> !busy);
  // R7
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_nz && mode != 2'd3) |=> busy);
  // R6
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (32'(wr_addr) < lim));
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_tgt)));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  // R9
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));
  // R7
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_valid) |-> busy);
endmodule

bind vdma_engine vdma_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .VRAM_BYTES(VRAM_BYTES),
  .CRAM_BYTES(CRAM_BYTES), .VSRAM_BYTES(VSRAM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len_lo(len_lo),
  .len_hi(len_hi), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_tgt(wr_tgt), .wr_addr(wr_addr), .busy(busy)
);

// File: tb/sim_vdma_engine.sv
`timescale 1ns/100ps
module sim_vdma_engine;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode = 0, tgt_sel = 0;
  logic [15:0] dst_base = 0;
  logic [7:0] stride = 0, src_lo = 0, src_mid = 0, src_hi = 0, len_lo = 0, len_hi = 0, fill_value = 0;
  logic rd_valid, rd_ready, wr_valid, wr_ready, busy;
  logic [23:0] rd_addr;
  logic [15:0] rd_data, vr_rd_addr, wr_addr;
  logic [7:0] vr_rd_data, wr_data;
  logic [1:0] wr_tgt;
  logic bp = 0, tick = 0;

  int checks = 0, errors = 0, cyc = 0, last_hs = -1, nw = 0, nr = 0, ne = 0;
  bit done = 0;
  int w_t[64], w_a[64], w_d[64], r_a[64], e_t[64], e_a[64], e_d[64], e_r[64];

  always #2.5 clk = ~clk;

  vdma_engine u0 (.*);

  assign rd_data    = rd_addr[15:0] ^ 16'hA5F0;
  assign vr_rd_data = vr_rd_addr[7:0] ^ 8'h3C;
  assign rd_ready   = !bp || tick;
  assign wr_ready   = !bp || !tick;

  always @(negedge clk) tick <= ~tick;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_valid && wr_ready) begin
      if (nw < 64) begin w_t[nw] <= wr_tgt; w_a[nw] <= wr_addr; w_d[nw] <= wr_data; end
      nw <= nw + 1;
      last_hs <= cyc;
    end
    if (rd_valid && rd_ready) begin
      if (nr < 64) r_a[nr] <= rd_addr;
      nr <= nr + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int wrapf(input int v, input int t);
    if (t == 1) return v % 128;
    if (t == 2) return v % 80;
    return v % 65536;
  endfunction

  task automatic ew(input int t, input int a, input int d);
    e_t[ne] = t; e_a[ne] = a; e_d[ne] = d; ne++;
  endtask

  task automatic launch(input int m, input int t, input int dst, input int st,
                        input int lo, input int mid, input int hi, input int len, input int fv);
    @(negedge clk);
    nw = 0; nr = 0; ne = 0;
    mode = 2'(m); tgt_sel = 2'(t); dst_base = 16'(dst); stride = 8'(st);
    src_lo = 8'(lo); src_mid = 8'(mid); src_hi = 8'(hi);
    len_lo = 8'(len); len_hi = 8'(len >> 8); fill_value = 8'(fv);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_and_compare(input string tag);
    int guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    chk(cyc - 1 == last_hs, "R7 busy falls after last write", cyc - 1, last_hs);
    chk(nw == ne, {tag, " write count"}, nw, ne);
    for (int i = 0; i < ne && i < nw; i++) begin
      chk(w_a[i] == e_a[i], {tag, " write addr"}, w_a[i], e_a[i]);
      chk(w_d[i] == e_d[i], {tag, " write data"}, w_d[i], e_d[i]);
      chk(w_t[i] == e_t[i], {tag, " write target"}, w_t[i], e_t[i]);
    end
  endtask

  // R1 R3 R6: memory mode with expected reads and writes
  task automatic mem_case(input string tag, input int t, input int dst, input int st,
                          input int lo, input int mid, input int hi, input int len, input int src_exp);
    int d, a, words, tt;
    launch(0, t, dst, st, lo, mid, hi, len, 0);
    chk(busy == 1, "R7 busy after start", busy, 1);
    tt = (t == 3) ? 0 : t;
    words = (len + 1) / 2;
    a = wrapf(dst, tt);
    for (int k = 0; k < words; k++) begin
      e_r[k] = (src_exp + 2 * k) & 24'hFFFFFF;
      d = (e_r[k] & 16'hFFFF) ^ 16'hA5F0;
      ew(tt, a, d >> 8);
      ew(tt, wrapf(a + 1, tt), d & 8'hFF);
      a = wrapf(a + st, tt);
    end
    finish_and_compare(tag);
    chk(nr == words, "R3 read count", nr, words);
    for (int k = 0; k < words && k < nr; k++)
      chk(r_a[k] == e_r[k], "R1 read address", r_a[k], e_r[k]);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R7 reset busy", busy, 0);
    chk(wr_valid == 0 && rd_valid == 0, "R9 reset requests", wr_valid, 0);
  endtask

  task automatic t_copy;
    // R4: target input CRAM ignored, VRAM wraps at 65536
    launch(1, 1, 16'hFFFE, 1, 8'h08, 0, 8'h80, 3, 0);
    for (int k = 0; k < 3; k++) ew(0, wrapf(16'hFFFE + k, 0), (8'h10 + k) ^ 8'h3C);
    finish_and_compare("R4 copy");
    chk(nr == 0, "R4 no system reads", nr, 0);
  endtask

  task automatic t_fill;
    // R5: fill with stride, target forced to VRAM
    launch(2, 2, 16'h0020, 16'h10, 0, 0, 8'h80, 4, 8'hAB);
    for (int k = 0; k < 4; k++) ew(0, 16'h20 + 16 * k, 8'hAB);
    finish_and_compare("R5 fill");
  endtask

  task automatic t_zero;
    // R2: zero length and mode 3 do nothing
    launch(2, 0, 0, 1, 0, 0, 0, 0, 8'h55);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R2 zero length busy", busy, 0);
    chk(nw == 0, "R2 zero length writes", nw, 0);
    launch(3, 0, 0, 1, 0, 0, 0, 4, 8'h55);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R2 mode 3 busy", busy, 0);
    chk(nw == 0 && nr == 0, "R2 mode 3 requests", nw, 0);
  endtask

  task automatic t_busy_ignore;
    // R8: second start during a throttled fill
    bp = 1;
    launch(2, 0, 16'h0300, 1, 0, 0, 8'h80, 6, 8'h77);
    repeat (2) @(negedge clk);
    mode = 0; dst_base = 16'h0500; len_lo = 2; fill_value = 8'h11; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 6; k++) ew(0, 16'h300 + k, 8'h77);
    finish_and_compare("R8 ignored start");
    chk(nr == 0, "R8 no memory reads", nr, 0);
    bp = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    mem_case("R3 mem vram", 0, 16'h0100, 2, 8'h10, 8'h02, 8'h41, 5, 24'h820420);
    mem_case("R1 bit23 cram wrap", 1, 16'h007F, 3, 8'h10, 8'h02, 8'hC1, 2, 24'h020420);
    bp = 1;
    mem_case("R6 vsram wrap throttled", 2, 78, 5, 8'h01, 0, 0, 4, 24'h000002);
    bp = 0;
    mem_case("R6 alias target", 3, 16'hFFFF, 1, 0, 0, 0, 2, 0);
    t_copy();
    t_fill();
    t_zero();
    t_busy_ignore();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R7 actual busy %0d expected 0", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule